// File: doc/BRIEF.md
# Read-Only Small-Page NAND Target Model

This block behaves as a NAND flash target that only serves reads. It sits on a parallel NAND-style bus and shares that bus across two banks. The bus has an 8-bit byte lane, one active-low enable per bank, active-low read and write strobes, and latch enables for command and address. A host first sends a read command. The command picks the starting column inside a 528-byte page: the first half, the second half or the spare area. The host then sends three address bytes, which the block turns into one flat byte pointer. Each read strobe after that returns the next stored byte.

All bus inputs are asynchronous to the system clock. They pass through a synchronizer before any decision is made. The block captures a command or an address byte when the write strobe rises, and it advances the pointer when the read strobe rises. Each bank has its own storage array. Every byte starts at 0xFF. A testbench fills the arrays through a separate write port. The array depth is a parameter, and the pointer wraps modulo that depth.

Top module: `nand_rd_target`

## Requirements
- R1: Bank select uses priority. When `ce0_n` is low, bank 0 is selected, whatever `ce1_n` is. When only `ce1_n` is low, bank 1 is selected. When both are high, every bus cycle is ignored: `dout_oe` stays 0 and no bank state changes.
- R2: After reset, `rdy` is 0. A selected bank that sees both strobes high sets its own `rdy` bit to 1. That bit never falls again until reset. With both strobes high, `dout_oe` is 0.
- R3: A command is a rising write strobe with the command latch high and the address latch low. Command 0xFF returns the bank to idle. Commands 0x00, 0x01 and 0x50 enter read modes 1, 2 and 3, and each of these clears the address-cycle count.
- R4: The first address byte after a read command sets the pointer to that byte. Mode 2 adds 256 and mode 3 adds 512.
- R5: The second address byte adds byte × 135168 (528 × 256) to the pointer. The third address byte adds byte × 528. All sums are taken modulo DEPTH.
- R6: While the bank is selected, the read strobe is low and both latches are low, `dout_oe` is 1 and `dout` shows the byte at the pointer. The rising read strobe moves the pointer to (pointer + 1) mod DEPTH.
- R7: Before any backdoor write, every stored byte reads as 0xFF.
- R8: Each bank keeps its own mode, pointer and address-cycle count. Traffic to one bank leaves the other bank's pointer unchanged.
- R9: Any of the following sets that bank's sticky `err` bit and is otherwise ignored:
  - an unknown command;
  - a fourth address byte;
  - an address byte while idle;
  - a write strobe with both latches equal, or with the read strobe low;
  - a read strobe edge with either latch high or with the write strobe low.

  The bank keeps serving later cycles.
- R10: A backdoor write with `bd_we` high stores `bd_data` at `bd_addr` of bank `bd_bank` on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce0_n | input | 1 | Bank 0 enable, active low, higher priority |
| ce1_n | input | 1 | Bank 1 enable, active low |
| re_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| din | input | 8 | Command or address byte from host |
| dout | output | 8 | Read byte to host |
| dout_oe | output | 1 | Drive enable for `dout` |
| rdy | output | 2 | Per-bank ready |
| err | output | 2 | Per-bank sticky protocol error |
| bd_we | input | 1 | Backdoor write enable |
| bd_bank | input | 1 | Backdoor bank index |
| bd_addr | input | PW | Backdoor byte address |
| bd_data | input | 8 | Backdoor byte |

## Verification
Two functions can fall in the same cycle. The first is selection arbitration: with both enables low, both banks are eligible for one strobe. The test drives both enables low during a read and then checks that the byte returned belongs to bank 0 at bank 0's model pointer. The second is error handling during a legal sequence: a fourth address byte arrives in the same sequence as valid reads. The test checks that `err` rises and that the next read still returns the byte at the unchanged pointer.

// File: rtl/nrt_pkg.sv
package nrt_pkg;
  localparam int unsigned PAGE_BYTES = 528;
  localparam int unsigned PAGES_PER_BLK = 256;

  typedef enum logic [1:0] {MD_IDLE, MD_RD1, MD_RD2, MD_RD3} mode_t;

  // command byte recognised as one of the four supported opcodes
  function automatic logic cmd_known(logic [7:0] c);
    return (c == 8'hFF) || (c == 8'h00) || (c == 8'h01) || (c == 8'h50);
  endfunction

  function automatic mode_t cmd_mode(logic [7:0] c);
    case (c)
      8'h00:   return MD_RD1;
      8'h01:   return MD_RD2;
      8'h50:   return MD_RD3;
      default: return MD_IDLE;
    endcase
  endfunction

  // column start inside a page, offset chosen by the read mode
  function automatic logic [31:0] col_start(mode_t m, logic [7:0] b);
    case (m)
      MD_RD2:  return 32'd256 + 32'(b);
      MD_RD3:  return 32'd512 + 32'(b);
      default: return 32'(b);
    endcase
  endfunction

  function automatic logic [31:0] wrap_add(logic [31:0] p, logic [31:0] a,
                                           int unsigned depth);
    return (p + a) % depth;
  endfunction
endpackage

// File: rtl/nrt_sync.sv
module nrt_sync #(
  parameter int unsigned W = 14,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= RST;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nrt_store.sv
module nrt_store #(
  parameter int unsigned DEPTH = 1000,
  parameter int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [PW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH] = '{default: 8'hFF};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nrt_bank.sv
module nrt_bank
  import nrt_pkg::*;
#(
  parameter int unsigned DEPTH = 1000,
  parameter int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          we_rise,
  input  logic          re_rise,
  input  logic          we_hi,
  input  logic          re_hi,
  input  logic          cle,
  input  logic          ale,
  input  logic [7:0]    din,
  output logic [PW-1:0] ptr,
  output logic          rdy,
  output logic          err,
  output logic          cmd_evt,
  output logic          addr_evt,
  output logic          rd_evt,
  output logic          err_evt
);
  mode_t         mode;
  logic [1:0]    acyc;
  logic          wr, bad_wr, bad_rd, addr_ok, cmd_ok;
  logic [PW-1:0] addr_ptr, inc_ptr;

  assign wr       = sel & we_rise;
  assign cmd_evt  = wr & cle & ~ale & re_hi;
  assign addr_evt = wr & ale & ~cle & re_hi;
  assign bad_wr   = wr & ((cle == ale) | ~re_hi);
  assign rd_evt   = sel & re_rise & ~cle & ~ale & we_hi;
  assign bad_rd   = sel & re_rise & (cle | ale | ~we_hi);
  assign cmd_ok   = cmd_known(din);
  assign addr_ok  = (mode != MD_IDLE) && (acyc < 2'd3);
  assign err_evt  = bad_wr | bad_rd | (cmd_evt & ~cmd_ok) | (addr_evt & ~addr_ok);

  always_comb begin
    case (acyc)
      2'd0:    addr_ptr = PW'(wrap_add(32'd0, col_start(mode, din), DEPTH));
      2'd1:    addr_ptr = PW'(wrap_add(32'(ptr),
                   32'(din) * (PAGE_BYTES * PAGES_PER_BLK), DEPTH));
      default: addr_ptr = PW'(wrap_add(32'(ptr), 32'(din) * PAGE_BYTES, DEPTH));
    endcase
    inc_ptr = PW'(wrap_add(32'(ptr), 32'd1, DEPTH));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MD_IDLE;
      acyc <= '0;
      ptr  <= '0;
      rdy  <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (sel & we_hi & re_hi) rdy <= 1'b1;
      if (err_evt) err <= 1'b1;
      if (cmd_evt & cmd_ok) begin
        mode <= cmd_mode(din);
        if (cmd_mode(din) != MD_IDLE) acyc <= '0;
      end
      if (addr_evt & addr_ok) begin
        ptr  <= addr_ptr;
        acyc <= acyc + 2'd1;
      end else if (rd_evt) begin
        ptr <= inc_ptr;
      end
    end
  end
endmodule

// File: rtl/nand_rd_target.sv
module nand_rd_target #(
  parameter int unsigned DEPTH = 1000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce0_n,
  input  logic          ce1_n,
  input  logic          re_n,
  input  logic          we_n,
  input  logic          cle,
  input  logic          ale,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_oe,
  output logic [1:0]    rdy,
  output logic [1:0]    err,
  input  logic          bd_we,
  input  logic          bd_bank,
  input  logic [PW-1:0] bd_addr,
  input  logic [7:0]    bd_data
);
  localparam int unsigned NBANK = 2;
  localparam int unsigned BW = 14;
  localparam logic [BW-1:0] BUS_IDLE = 14'h3C00;

  logic [BW-1:0] bus_s;
  logic [NBANK-1:0] ce_s;
  logic re_s, we_s, cle_s, ale_s, re_q, we_q, re_rise, we_rise;
  logic [7:0] din_s;

  // internal events, brought out for the checker
  logic [NBANK-1:0] bank_sel, rd_evt, wr_evt, err_evt, cmd_evt, addr_evt;
  logic [7:0] rd_byte [NBANK];
  logic [PW-1:0] ptr [NBANK];

  nrt_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST(BUS_IDLE)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ce0_n, ce1_n, re_n, we_n, cle, ale, din}),
    .q(bus_s)
  );

  assign ce_s[0] = bus_s[13];
  assign ce_s[1] = bus_s[12];
  assign re_s    = bus_s[11];
  assign we_s    = bus_s[10];
  assign cle_s   = bus_s[9];
  assign ale_s   = bus_s[8];
  assign din_s   = bus_s[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      re_q <= 1'b1;
      we_q <= 1'b1;
    end else begin
      re_q <= re_s;
      we_q <= we_s;
    end
  end

  assign re_rise = re_s & ~re_q;
  assign we_rise = we_s & ~we_q;

  // lower index wins
  assign bank_sel[0] = ~ce_s[0];
  assign bank_sel[1] = ce_s[0] & ~ce_s[1];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    nrt_bank #(.DEPTH(DEPTH), .PW(PW)) i_bank (
      .clk(clk), .rst_n(rst_n), .sel(bank_sel[b]),
      .we_rise(we_rise), .re_rise(re_rise), .we_hi(we_s), .re_hi(re_s),
      .cle(cle_s), .ale(ale_s), .din(din_s),
      .ptr(ptr[b]), .rdy(rdy[b]), .err(err[b]),
      .cmd_evt(cmd_evt[b]), .addr_evt(addr_evt[b]),
      .rd_evt(rd_evt[b]), .err_evt(err_evt[b])
    );

    nrt_store #(.DEPTH(DEPTH), .PW(PW)) i_store (
      .clk(clk), .wr_en(bd_we && (32'(bd_bank) == b)),
      .wr_addr(bd_addr), .wr_data(bd_data),
      .rd_addr(ptr[b]), .rd_data(rd_byte[b])
    );

    assign wr_evt[b] = cmd_evt[b] | addr_evt[b];
  end

  always_comb begin
    dout = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bank_sel[b]) dout = rd_byte[b];
    end
  end

  assign dout_oe = (|bank_sel) & ~re_s & we_s & ~cle_s & ~ale_s;
endmodule

// File: rtl/nrt_chk.sv
module nrt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       re_n,
  input logic       dout_oe,
  input logic [1:0] rdy,
  input logic [1:0] err,
  input logic [1:0] bank_sel,
  input logic [1:0] rd_evt,
  input logic [1:0] wr_evt,
  input logic [1:0] err_evt
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err != 2'b00) |=> ((err & $past(err)) == $past(err))); // R9

  AST_ERR_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt != 2'b00) |=> ((err & $past(err_evt)) == $past(err_evt))); // R9

  AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy != 2'b00) |=> ((rdy & $past(rdy)) == $past(rdy))); // R2

  AST_OE_AFTER_RE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> !$past(re_n, 2)); // R6

  AST_ONE_BANK_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0((rd_evt | wr_evt) & bank_sel) && ((rd_evt | wr_evt) & ~bank_sel) == 2'b00); // R1
endmodule

bind nand_rd_target nrt_chk i_chk (
  .clk(clk), .rst_n(rst_n), .re_n(re_n), .dout_oe(dout_oe),
  .rdy(rdy), .err(err), .bank_sel(bank_sel), .rd_evt(rd_evt),
  .wr_evt(wr_evt), .err_evt(err_evt)
);

// File: tb/test_nand_rd_target.sv
`timescale 1ns/1ps
module test_nand_rd_target;
  localparam int unsigned DEPTH = 1000;
  localparam int unsigned PW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic ce0_n = 1, ce1_n = 1, re_n = 1, we_n = 1, cle = 0, ale = 0;
  logic [7:0] din = 0, dout;
  logic dout_oe;
  logic [1:0] rdy, err;
  logic bd_we = 0, bd_bank = 0;
  logic [PW-1:0] bd_addr = 0;
  logic [7:0] bd_data = 0;

  int checks = 0, errors = 0;
  int ep [2] = '{0, 0};
  bit loaded = 0;

  always #2.5 clk = ~clk;

  nand_rd_target #(.DEPTH(DEPTH)) i_nand_rd_target (
    .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1_n(ce1_n), .re_n(re_n),
    .we_n(we_n), .cle(cle), .ale(ale), .din(din), .dout(dout),
    .dout_oe(dout_oe), .rdy(rdy), .err(err), .bd_we(bd_we),
    .bd_bank(bd_bank), .bd_addr(bd_addr), .bd_data(bd_data)
  );

  function automatic logic [7:0] pat(int b, int a);
    return 8'((a * 37 + b * 101 + 5) & 255);
  endfunction

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pick(int b);
    ce0_n = (b != 0);
    ce1_n = (b != 1);
    ticks(4);
  endtask

  task automatic wr_byte(bit is_cmd, logic [7:0] v);
    cle = is_cmd; ale = !is_cmd; din = v;
    ticks(2); we_n = 0; ticks(4); we_n = 1; ticks(4);
    cle = 0; ale = 0; ticks(4);
  endtask

  task automatic open_rd(logic [7:0] c, logic [7:0] a0, logic [7:0] a1, logic [7:0] a2);
    wr_byte(1, c); wr_byte(0, a0); wr_byte(0, a1); wr_byte(0, a2);
  endtask

  task automatic rd_expect(int b, string req);
    re_n = 0; ticks(5);
    chk(dout_oe, 1, req);
    chk(dout, loaded ? pat(b, ep[b]) : 8'hFF, req);
    re_n = 1; ticks(5);
    ep[b] = (ep[b] + 1) % DEPTH;
  endtask

  task automatic t_reset;
    chk(rdy, 0, "R2 reset rdy");
    chk(err, 0, "R9 reset err");
    chk(dout_oe, 0, "R2 reset oe");
  endtask

  task automatic t_erased;
    pick(0);
    chk(rdy, 2'b01, "R2 rdy bank0 only");
    chk(dout_oe, 0, "R2 oe released");
    rd_expect(0, "R7 erased");
  endtask

  task automatic t_load;
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < DEPTH; a++) begin
        bd_we = 1; bd_bank = b[0]; bd_addr = PW'(a); bd_data = pat(b, a);
        @(negedge clk);
      end
    bd_we = 0;
    loaded = 1;
  endtask

  task automatic t_modes;
    pick(0);
    open_rd(8'h00, 8'h10, 0, 0); ep[0] = 16;
    rd_expect(0, "R3 R4 mode1"); rd_expect(0, "R6 seq"); rd_expect(0, "R6 seq");
    open_rd(8'h01, 8'd5, 0, 8'd1); ep[0] = (256 + 5 + 528) % DEPTH;
    rd_expect(0, "R4 R5 mode2");
    open_rd(8'h50, 8'd3, 8'd1, 0); ep[0] = (512 + 3 + 135168) % DEPTH;
    rd_expect(0, "R4 R5 mode3");
  endtask

  task automatic t_wrap;
    open_rd(8'h00, 8'd158, 8'd5, 0); ep[0] = (158 + 5 * 135168) % DEPTH;
    chk(ep[0], 998, "R6 wrap setup");
    rd_expect(0, "R6 wrap"); rd_expect(0, "R6 wrap"); rd_expect(0, "R6 wrap R10");
  endtask

  task automatic t_banks;
    pick(1);
    chk(rdy, 2'b11, "R2 rdy bank1");
    open_rd(8'h01, 8'd2, 0, 0); ep[1] = 258;
    rd_expect(1, "R8 R10 bank1");
    pick(0);
    rd_expect(0, "R8 bank0 kept");
  endtask

  task automatic t_priority;
    ce0_n = 0; ce1_n = 0; ticks(4);
    rd_expect(0, "R1 both low");
    ce0_n = 1; ce1_n = 1; ticks(4);
    re_n = 0; ticks(5);
    chk(dout_oe, 0, "R1 none selected");
    re_n = 1; ticks(5);
    wr_byte(1, 8'h50);
    pick(0);
    rd_expect(0, "R1 ignored state");
  endtask

  task automatic t_errors;
    pick(1);
    open_rd(8'h00, 8'd1, 0, 0); ep[1] = 1;
    chk(err, 0, "R9 legal no err");
    wr_byte(0, 8'd9);
    chk(err, 2'b10, "R9 fourth addr");
    rd_expect(1, "R9 ptr unchanged");
    pick(0);
    wr_byte(1, 8'hFF);
    wr_byte(0, 8'd7);
    chk(err, 2'b11, "R3 R9 addr in idle");
    rd_expect(0, "R9 idle ignored");
    open_rd(8'h00, 0, 0, 0); ep[0] = 0;
    rd_expect(0, "R9 keeps serving");
  endtask

  initial begin
    ticks(4); rst_n = 1; ticks(4);
    t_reset;
    t_erased;
    t_load;
    t_modes;
    t_wrap;
    t_banks;
    t_priority;
    t_errors;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule